// File: doc/BRIEF.md
# Output Swing Calibration Controller

This controller sets a transmitter's output swing once, at start-up. Two thermometer-coded enable words switch parallel resistor legs into the driver: one word for the pull-up (high) side and one for the pull-down (low) side. Two external comparators feed the block. One reports that the true output is above the high reference. The other reports that the complementary output is below the low reference. Both comparator inputs are asynchronous, so each passes through a two-flop synchronizer.

The search only ever adds legs. After each leg change the controller waits a programmable number of settle cycles. It then makes one decision:
- If the high-side comparison fails, it adds a high leg.
- If the high side passes but the low-side comparison fails, it adds a low leg.
- If both pass, it stops and holds both codes.

A slow mode timer runs in parallel with the search. While the timer runs, the driver input is forced high. When the fixed period ends, a multiplexer hands the driver the live data stream. From that point the leg codes are frozen.

Top module: `swing_cal_ctrl`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears both leg codes, cal_done and cal_fail, sets cal_mode to 1 and restarts the mode timer and the search. This holds whether reset comes at start-up or in the middle of a run.
- R2: drv_data is 1 whenever cal_mode is 1, and equals data_in whenever cal_mode is 0, in the same cycle.
- R3: cal_mode stays 1 for exactly CAL_PERIOD clock edges after reset is released, then drops to 0 and stays 0 until the next reset.
- R4: While the synchronized high comparison (cmp_hi_above) is 0, each decision adds one high-side leg and leaves the low-side code unchanged.
- R5: A low-side leg is added only at a decision where the high comparison is 1 and the synchronized low comparison (cmp_lo_below) is 0.
- R6: At a decision where both comparisons are 1, cal_done rises and both codes are held from then on.
- R7: Each code is a thermometer word that grows from bit 0 upward. One step shifts it left by one and fills bit 0 with 1. No bit is ever cleared outside reset.
- R8: If both comparisons are already 1 after reset, the first decision sets cal_done with both codes still 0.
- R9: A decision that must add a leg to a side whose code is already all ones adds nothing. It raises cal_fail and cal_done instead. cal_fail stays 1 until reset.
- R10: The first decision falls settle_cycles+2 edges after reset release. Each later decision falls settle_cycles+2 edges after the previous leg change. settle_cycles must be at least 1.
- R11: Once cal_mode is 0, neither leg code changes, even if the search has not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| settle_cycles | input | SETTLE_W | Wait after each leg change before a decision |
| cmp_hi_above | input | 1 | Asynchronous comparator: true output above high reference |
| cmp_lo_below | input | 1 | Asynchronous comparator: complementary output below low reference |
| data_in | input | 1 | Live transmit data |
| hi_legs | output | LEG_W | High-side leg enables, thermometer code |
| lo_legs | output | LEG_W | Low-side leg enables, thermometer code |
| cal_mode | output | 1 | 1 during the calibration period |
| drv_data | output | 1 | Data presented to the driver |
| cal_done | output | 1 | Search finished, by convergence or saturation |
| cal_fail | output | 1 | A side saturated with its comparison still failing |

## Verification
The bench models the comparators by comparing the number of ones in each code with a target. Every code change therefore reaches the block one edge later, and then needs two more synchronizer edges. A leg change decided at one edge is visible just after that edge. The next decision is due settle_cycles+2 edges later, so the bench counts edges from reset release and samples at the falling edge that follows the expected edge, and also one edge earlier, to confirm that nothing moved too soon. The mode flag is sampled at edges CAL_PERIOD-1 and CAL_PERIOD. The multiplexer is combinational and is checked in the same cycle that data_in changes.

// File: rtl/swing_cal_pkg.sv
package swing_cal_pkg;

    localparam int LEG_W_DEF    = 8;
    localparam int SETTLE_W_DEF = 8;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_DECIDE = 2'd1,
        ST_HOLD   = 2'd2
    } cal_state_e;

    typedef struct packed {
        logic hi_ok;
        logic lo_ok;
    } cmp_pair_t;

    function automatic cmp_pair_t pack_cmp(input logic hi, input logic lo);
        cmp_pair_t p;
        p.hi_ok = hi;
        p.lo_ok = lo;
        return p;
    endfunction

endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end
endmodule

// File: rtl/cal_mode_timer.sv
module cal_mode_timer #(
    parameter int PERIOD = 2000
) (
    input  logic clk,
    input  logic rst,
    output logic mode_o
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= 1'b1;
        end else if (mode_q) begin
            if (cnt_q == LAST) begin
                mode_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign mode_o = mode_q;

    // R3: once data mode is entered it stays until reset
    a_r3_mode_sticky: assert property (@(posedge clk) disable iff (rst)
        !mode_q |=> !mode_q);
endmodule

// File: rtl/cal_leg_search.sv
module cal_leg_search
    import swing_cal_pkg::*;
#(
    parameter int LEG_W    = LEG_W_DEF,
    parameter int SETTLE_W = SETTLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  cmp_pair_t           cmp_i,
    output logic [LEG_W-1:0]    hi_legs_o,
    output logic [LEG_W-1:0]    lo_legs_o,
    output logic                done_o,
    output logic                fail_o
);
    cal_state_e          state_q;
    logic [SETTLE_W-1:0] wait_q;
    logic [LEG_W-1:0]    hi_q;
    logic [LEG_W-1:0]    lo_q;
    logic                done_q;
    logic                fail_q;

    logic hi_full;
    logic lo_full;
    assign hi_full = hi_q[LEG_W-1];
    assign lo_full = lo_q[LEG_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SETTLE;
            wait_q  <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else if (!mode_i) begin
            state_q <= ST_HOLD;
        end else begin
            unique case (state_q)
                ST_SETTLE: begin
                    if (wait_q >= settle_i) begin
                        state_q <= ST_DECIDE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_DECIDE: begin
                    wait_q <= '0;
                    if (!cmp_i.hi_ok) begin
                        if (hi_full) begin
                            fail_q  <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_HOLD;
                        end else begin
                            hi_q    <= {hi_q[LEG_W-2:0], 1'b1};
                            state_q <= ST_SETTLE;
                        end
                    end else if (!cmp_i.lo_ok) begin
                        if (lo_full) begin
                            fail_q  <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_HOLD;
                        end else begin
                            lo_q    <= {lo_q[LEG_W-2:0], 1'b1};
                            state_q <= ST_SETTLE;
                        end
                    end else begin
                        done_q  <= 1'b1;
                        state_q <= ST_HOLD;
                    end
                end
                default: begin
                    state_q <= ST_HOLD;
                end
            endcase
        end
    end

    assign hi_legs_o = hi_q;
    assign lo_legs_o = lo_q;
    assign done_o    = done_q;
    assign fail_o    = fail_q;

    logic cmp_hi_ok;
    assign cmp_hi_ok = cmp_i.hi_ok;

    // R7: each code either holds or takes exactly one thermometer step
    a_r7_hi_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (hi_q == $past(hi_q)) || (hi_q == {$past(hi_q[LEG_W-2:0]), 1'b1}));
    a_r7_lo_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lo_q == $past(lo_q)) || (lo_q == {$past(lo_q[LEG_W-2:0]), 1'b1}));
    // R4: both sides never move together
    a_r4_one_side: assert property (@(posedge clk) disable iff (rst)
        !$stable(hi_q) |-> $stable(lo_q));
    // R5: a low leg is added only after the high side passed
    a_r5_lo_after_hi: assert property (@(posedge clk) disable iff (rst)
        !$stable(lo_q) |-> $past(cmp_hi_ok));
    // R6: a finished search holds both codes
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        done_q |=> $stable(hi_q) && $stable(lo_q) && done_q);
    // R9: the failure flag is sticky
    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        fail_q |=> fail_q);
    // R11: codes frozen in data mode
    a_r11_freeze: assert property (@(posedge clk) disable iff (rst)
        !mode_i |=> $stable(hi_q) && $stable(lo_q));
endmodule

// File: rtl/swing_cal_ctrl.sv
module swing_cal_ctrl
    import swing_cal_pkg::*;
#(
    parameter int LEG_W      = LEG_W_DEF,
    parameter int SETTLE_W   = SETTLE_W_DEF,
    parameter int CAL_PERIOD = 2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                cmp_hi_above,
    input  logic                cmp_lo_below,
    input  logic                data_in,
    output logic [LEG_W-1:0]    hi_legs,
    output logic [LEG_W-1:0]    lo_legs,
    output logic                cal_mode,
    output logic                drv_data,
    output logic                cal_done,
    output logic                cal_fail
);
    logic [1:0] cmp_sync;
    cmp_pair_t  cmp_s;
    logic       mode_w;

    cal_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({cmp_hi_above, cmp_lo_below}),
        .sync_o  (cmp_sync)
    );

    assign cmp_s = pack_cmp(cmp_sync[1], cmp_sync[0]);

    cal_mode_timer #(.PERIOD(CAL_PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .mode_o (mode_w)
    );

    cal_leg_search #(.LEG_W(LEG_W), .SETTLE_W(SETTLE_W)) u_search (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_w),
        .settle_i  (settle_cycles),
        .cmp_i     (cmp_s),
        .hi_legs_o (hi_legs),
        .lo_legs_o (lo_legs),
        .done_o    (cal_done),
        .fail_o    (cal_fail)
    );

    assign cal_mode = mode_w;
    assign drv_data = mode_w ? 1'b1 : data_in;

    // R1: the cycle after reset shows the cleared state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (hi_legs == '0) && (lo_legs == '0) && cal_mode && !cal_done && !cal_fail);
endmodule

// File: tb/swing_cal_ctrl_tb_top.sv
module swing_cal_ctrl_tb_top;
    localparam int LEG_W      = 8;
    localparam int SETTLE_W   = 8;
    localparam int CAL_PERIOD = 2000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [SETTLE_W-1:0] settle_cycles = 8'd3;
    logic                data_in = 1'b0;
    logic [LEG_W-1:0]    hi_legs;
    logic [LEG_W-1:0]    lo_legs;
    logic                cal_mode;
    logic                drv_data;
    logic                cal_done;
    logic                cal_fail;
    int                  tgt_hi = 0;
    int                  tgt_lo = 0;
    logic                cmp_hi_above;
    logic                cmp_lo_below;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    assign cmp_hi_above = ($countones(hi_legs) >= tgt_hi);
    assign cmp_lo_below = ($countones(lo_legs) >= tgt_lo);

    swing_cal_ctrl #(.LEG_W(LEG_W), .SETTLE_W(SETTLE_W), .CAL_PERIOD(CAL_PERIOD)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .settle_cycles (settle_cycles),
        .cmp_hi_above  (cmp_hi_above),
        .cmp_lo_below  (cmp_lo_below),
        .data_in       (data_in),
        .hi_legs       (hi_legs),
        .lo_legs       (lo_legs),
        .cal_mode      (cal_mode),
        .drv_data      (drv_data),
        .cal_done      (cal_done),
        .cal_fail      (cal_fail)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input int th, input int tl, input logic [SETTLE_W-1:0] st);
        @(negedge clk);
        rst = 1'b1;
        tgt_hi = th;
        tgt_lo = tl;
        settle_cycles = st;
        edges(2);
        rst = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (cal_done) break;
            edges(1);
        end
    endtask

    task automatic t_reset_state;
        do_reset(2, 1, 8'd3);
        chk(hi_legs == 0, "R1 hi_legs", 32'(hi_legs), 0);
        chk(lo_legs == 0, "R1 lo_legs", 32'(lo_legs), 0);
        chk(cal_mode == 1'b1, "R1 cal_mode", 32'(cal_mode), 1);
        chk(!cal_done && !cal_fail, "R1 done/fail", {cal_done, cal_fail}, 0);
    endtask

    task automatic t_step_timing;
        do_reset(2, 1, 8'd3);
        edges(4);
        chk(hi_legs == 8'h00, "R10 no step before edge 5", 32'(hi_legs), 0);
        edges(1);
        chk(hi_legs == 8'h01, "R10 first step at edge 5", 32'(hi_legs), 1);
        edges(5);
        chk(hi_legs == 8'h03 && lo_legs == 8'h00, "R4 second high step, low untouched", {hi_legs, lo_legs}, 32'h0300);
        edges(5);
        chk(lo_legs == 8'h01 && hi_legs == 8'h03, "R5 low step after high passes", {hi_legs, lo_legs}, 32'h0301);
        edges(4);
        chk(!cal_done, "R6 not done at edge 19", 32'(cal_done), 0);
        edges(1);
        chk(cal_done && !cal_fail, "R6 done at edge 20", {cal_done, cal_fail}, 32'h2);
        edges(30);
        chk(hi_legs == 8'h03 && lo_legs == 8'h01, "R6 codes held", {hi_legs, lo_legs}, 32'h0301);
    endtask

    task automatic t_converge_full;
        do_reset(5, 7, 8'd2);
        wait_done(400);
        chk(hi_legs == 8'h1F, "R7 high thermometer", 32'(hi_legs), 32'h1F);
        chk(lo_legs == 8'h7F, "R7 low thermometer", 32'(lo_legs), 32'h7F);
        chk(cal_done && !cal_fail, "R6 converged", {cal_done, cal_fail}, 32'h2);
    endtask

    task automatic t_already_pass;
        do_reset(0, 0, 8'd3);
        edges(5);
        chk(cal_done && hi_legs == 0 && lo_legs == 0, "R8 done with zero codes",
            {cal_done, hi_legs, lo_legs}, 32'h10000);
    endtask

    task automatic t_saturate;
        do_reset(9, 0, 8'd2);
        wait_done(400);
        chk(hi_legs == 8'hFF && lo_legs == 8'h00, "R9 high saturated", {hi_legs, lo_legs}, 32'hFF00);
        chk(cal_fail && cal_done, "R9 fail and done", {cal_fail, cal_done}, 32'h3);
        edges(20);
        chk(cal_fail && hi_legs == 8'hFF, "R9 fail sticky", {cal_fail, hi_legs}, 32'h1FF);
        do_reset(3, 9, 8'd2);
        wait_done(400);
        chk(hi_legs == 8'h07 && lo_legs == 8'hFF && cal_fail, "R9 low saturated",
            {cal_fail, hi_legs, lo_legs}, 32'h107FF);
    endtask

    task automatic t_mode_and_mux;
        do_reset(8, 8, 8'd200);
        data_in = 1'b0;
        edges(CAL_PERIOD - 1);
        chk(cal_mode == 1'b1, "R3 mode high at edge PERIOD-1", 32'(cal_mode), 1);
        chk(drv_data == 1'b1, "R2 forced high in calibration", 32'(drv_data), 1);
        edges(1);
        chk(cal_mode == 1'b0, "R3 mode low at edge PERIOD", 32'(cal_mode), 0);
        chk(!cal_done, "R11 search unfinished", 32'(cal_done), 0);
        #1;
        chk(drv_data == 1'b0, "R2 data 0 routed", 32'(drv_data), 0);
        data_in = 1'b1;
        #1;
        chk(drv_data == 1'b1, "R2 data 1 routed", 32'(drv_data), 1);
        data_in = 1'b0;
        #1;
        chk(drv_data == 1'b0, "R2 data 0 again", 32'(drv_data), 0);
        begin
            logic [LEG_W-1:0] h0;
            logic [LEG_W-1:0] l0;
            h0 = hi_legs;
            l0 = lo_legs;
            edges(600);
            chk(hi_legs == h0 && lo_legs == l0, "R11 codes frozen", {hi_legs, lo_legs}, {h0, l0});
            chk(cal_mode == 1'b0, "R3 mode stays low", 32'(cal_mode), 0);
        end
    endtask

    task automatic t_mid_reset;
        do_reset(6, 6, 8'd3);
        edges(40);
        do_reset(6, 6, 8'd3);
        chk(hi_legs == 0 && lo_legs == 0 && cal_mode && !cal_done, "R1 mid-run reset",
            {cal_mode, cal_done, hi_legs, lo_legs}, 32'h20000);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_step_timing();
        t_converge_full();
        t_already_pass();
        t_saturate();
        t_mode_and_mux();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule